// File: doc/BRIEF.md
# Translation Unit Fault Interrupt and Control Registers

This block is the register front end of a small address-translation unit. It keeps the control bits that switch translation, hardware table walking and emulator lookup on, and it collects fault event pulses from the translation datapath into sticky status bits. It turns the enabled ones into one interrupt line and records the virtual address of the first fault that arrives while no enabled fault is pending. Software reads and writes it through a single-cycle register port addressed by word index.

A configuration register carries the idle-mode field and the auto-idle bit. It also has a soft-reset trigger: one write puts every register back to its default, and a reset-done flag stays low for a fixed number of cycles. While the sequence runs, the block ignores register writes and fault events. A read-only revision word reports the major and minor version.

Top module: `mmu_fault_regs`

## Requirements
- R1: After hardware reset every word reads as follows: index 1 (configuration) reads 0, index 2 (system status) reads 1, and indices 3 (interrupt status), 4 (interrupt enable), 5 (control) and 6 (fault address) read 0. Index 0 holds the revision, index 7 reads 0, and `irq` is 0.
- R2: A high `fault_evt[k]` in a cycle sets interrupt-status bit k at the next edge. Bit 0 is TLB miss, bit 1 translation fault, bit 2 emulator miss, bit 3 table-walk fault and bit 4 multi-hit fault. A set bit stays set until it is cleared.
- R3: A write to index 3 clears each status bit whose written bit is 1 and leaves the others alone. An event on the same bit in the same cycle wins over the clear.
- R4: In the cycle after the register edge, `irq` is 1 exactly when some status bit and its enable bit (index 4, same bit order) are both 1.
- R5: When any event arrives and no status bit with its enable set is pending before that edge, index 6 captures `fault_va`. Otherwise index 6 keeps its value.
- R6: Control (index 5) stores bit 1 (translation enable, `xlat_en`), bit 2 (table walk, `walk_en`, which is driven only while bit 1 is also set) and bit 3 (emulator access, `emu_tlb_en`). Every other bit reads 0.
- R7: Configuration bit 0 is auto-idle (`auto_idle`). Bits 4:3 select the idle mode (0 force, 1 none, 2 smart). A write of 3 to that field leaves the previous mode in place.
- R8: Writing configuration bit 1 as 1 starts a soft reset. From the next edge all registers hold their defaults, configuration bit 1 reads 1 and system-status bit 0 reads 0. System-status bit 0 reads 1 again exactly 16 edges after the starting edge.
- R9: While a soft reset runs, register writes and fault events have no effect.
- R10: Index 0 reads the major version in bits 7:4 and the minor version in bits 3:0, with 1 and 1 by default. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_we | input | 1 | Write strobe of the register port |
| reg_addr | input | 3 | Word index of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| fault_evt | input | 5 | Fault event pulses, one per source |
| fault_va | input | 32 | Virtual address that goes with the event |
| irq | output | 1 | Interrupt request |
| xlat_en | output | 1 | Translation enable |
| walk_en | output | 1 | Hardware table walk enable |
| emu_tlb_en | output | 1 | Emulator TLB access enable |
| idle_mode | output | 2 | Selected idle mode |
| auto_idle | output | 1 | Auto-idle bit |

## Verification
The assertions assume that `fault_va` is valid in every cycle in which `fault_evt` is non-zero. They also assume that a level held on an event line counts as one new event per cycle, and that the register port sees at most one write per cycle. The stimulus keeps to these rules by driving event pulses, addresses and writes together on the falling edge and returning every strobe to zero before the next edge. Random patterns cover single and multiple simultaneous events, clears that collide with new events, and enable changes while faults are pending. Directed cases cover the reserved idle code and the soft-reset window.

// File: rtl/mfr_pkg.sv
package mfr_pkg;
   typedef enum logic [2:0] {
      RA_REV   = 3'd0,
      RA_CFG   = 3'd1,
      RA_SYS   = 3'd2,
      RA_ISTAT = 3'd3,
      RA_IEN   = 3'd4,
      RA_CTRL  = 3'd5,
      RA_FADDR = 3'd6,
      RA_NONE  = 3'd7
   } reg_idx_e;

   typedef enum logic [1:0] {
      IDLE_FORCE = 2'd0,
      IDLE_NONE  = 2'd1,
      IDLE_SMART = 2'd2,
      IDLE_RSVD  = 2'd3
   } idle_mode_e;

   localparam int CFG_AUTOIDLE = 0;
   localparam int CFG_SRST     = 1;
   localparam int CFG_IDLE_LO  = 3;
   localparam int CTRL_XLAT    = 1;
   localparam int CTRL_WALK    = 2;
   localparam int CTRL_EMU     = 3;
endpackage

// File: rtl/mfr_softrst.sv
module mfr_softrst #(
   parameter int RST_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CNT_W = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

   if (RST_CYCLES < 2) begin : g_bad_cycles
      $error("mfr_softrst: RST_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_LOAD;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy = busy_q;

   // R8: a start always opens the window
   p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy_q);
   // R8: the counter never exceeds its load value while busy
   p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q <= CNT_LOAD));
endmodule

// File: rtl/mfr_irq.sv
module mfr_irq #(
   parameter int NUM_SRC        = 5,
   parameter int VA_W           = 32,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hold,
   input  logic [NUM_SRC-1:0] evt,
   input  logic [VA_W-1:0]    va,
   input  logic               clr_we,
   input  logic [NUM_SRC-1:0] clr_mask,
   input  logic               en_we,
   input  logic [NUM_SRC-1:0] en_wdata,
   output logic [NUM_SRC-1:0] status,
   output logic [NUM_SRC-1:0] enable,
   output logic [VA_W-1:0]    faddr,
   output logic               irq
);
   logic [NUM_SRC-1:0] enable_q;
   logic [VA_W-1:0]    faddr_q;
   logic               pending;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     bit_q <= 1'b0;
         else if (hold)                  bit_q <= 1'b0;
         else if (evt[i])                bit_q <= 1'b1;
         else if (clr_we && clr_mask[i]) bit_q <= 1'b0;
      end
      assign status[i] = bit_q;
   end

   assign pending = |(status & enable_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
         faddr_q  <= '0;
      end else if (hold) begin
         enable_q <= '0;
         faddr_q  <= '0;
      end else begin
         if (en_we) enable_q <= en_wdata;
         if ((|evt) && !pending) faddr_q <= va;
      end
   end

   if (IRQ_REGISTERED) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pending;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = pending;
   end

   assign enable = enable_q;
   assign faddr  = faddr_q;

   // R2: status bits are sticky without a clear or soft reset
   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !clr_we) |=> ((status & $past(status)) == $past(status)));
   // R2: an event always sets its bit
   p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |=> ((status & $past(evt)) == $past(evt)));
   // R5: the first fault address is kept while an enabled fault pends
   p_keep_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && pending) |=> $stable(faddr_q));
endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs
   import mfr_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter int VA_W           = 32,
   parameter int NUM_SRC        = 5,
   parameter int RST_CYCLES     = 16,
   parameter int REV_MAJOR      = 1,
   parameter int REV_MINOR      = 1,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [2:0]         reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_SRC-1:0] fault_evt,
   input  logic [VA_W-1:0]    fault_va,
   output logic               irq,
   output logic               xlat_en,
   output logic               walk_en,
   output logic               emu_tlb_en,
   output logic [1:0]         idle_mode,
   output logic               auto_idle
);
   localparam logic [3:0] REV_MAJ4 = REV_MAJOR[3:0];
   localparam logic [3:0] REV_MIN4 = REV_MINOR[3:0];

   if (DATA_W < 8 || VA_W > DATA_W || NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_width
      $error("mmu_fault_regs: width parameters out of range");
   end
   if (REV_MAJOR > 15 || REV_MINOR > 15) begin : g_bad_rev
      $error("mmu_fault_regs: revision fields are four bits");
   end

   reg_idx_e idx;
   logic     busy, srst_start, hold, wr_ok;
   logic [3:1] ctrl_q;
   idle_mode_e idle_q;
   logic     autoidle_q;
   logic [NUM_SRC-1:0] status, enable;
   logic [VA_W-1:0]    faddr;
   logic [1:0]         wr_idle;

   assign idx        = reg_idx_e'(reg_addr);
   assign wr_ok      = reg_we && !busy;
   assign srst_start = wr_ok && (idx == RA_CFG) && reg_wdata[CFG_SRST];
   assign hold       = srst_start || busy;
   assign wr_idle    = reg_wdata[CFG_IDLE_LO +: 2];

   mfr_softrst #(.RST_CYCLES(RST_CYCLES)) i_softrst (
      .clk   (clk),
      .rst_n (rst_n),
      .start (srst_start),
      .busy  (busy)
   );

   mfr_irq #(
      .NUM_SRC        (NUM_SRC),
      .VA_W           (VA_W),
      .IRQ_REGISTERED (IRQ_REGISTERED)
   ) i_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (hold),
      .evt      (fault_evt),
      .va       (fault_va),
      .clr_we   (wr_ok && (idx == RA_ISTAT)),
      .clr_mask (reg_wdata[NUM_SRC-1:0]),
      .en_we    (wr_ok && (idx == RA_IEN)),
      .en_wdata (reg_wdata[NUM_SRC-1:0]),
      .status   (status),
      .enable   (enable),
      .faddr    (faddr),
      .irq      (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         idle_q     <= IDLE_FORCE;
         autoidle_q <= 1'b0;
      end else if (hold) begin
         ctrl_q     <= '0;
         idle_q     <= IDLE_FORCE;
         autoidle_q <= 1'b0;
      end else if (wr_ok) begin
         if (idx == RA_CTRL) ctrl_q <= reg_wdata[CTRL_EMU:CTRL_XLAT];
         if (idx == RA_CFG) begin
            autoidle_q <= reg_wdata[CFG_AUTOIDLE];
            if (wr_idle != IDLE_RSVD) idle_q <= idle_mode_e'(wr_idle);
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (idx)
         RA_REV:   reg_rdata[7:0] = {REV_MAJ4, REV_MIN4};
         RA_CFG: begin
            reg_rdata[CFG_AUTOIDLE]       = autoidle_q;
            reg_rdata[CFG_SRST]           = busy;
            reg_rdata[CFG_IDLE_LO +: 2]   = idle_q;
         end
         RA_SYS:   reg_rdata[0] = !busy;
         RA_ISTAT: reg_rdata[NUM_SRC-1:0] = status;
         RA_IEN:   reg_rdata[NUM_SRC-1:0] = enable;
         RA_CTRL:  reg_rdata[CTRL_EMU:CTRL_XLAT] = ctrl_q;
         RA_FADDR: reg_rdata[VA_W-1:0] = faddr;
         default:  reg_rdata = '0;
      endcase
   end

   assign xlat_en    = ctrl_q[CTRL_XLAT];
   assign walk_en    = ctrl_q[CTRL_WALK] && ctrl_q[CTRL_XLAT];
   assign emu_tlb_en = ctrl_q[CTRL_EMU];
   assign idle_mode  = idle_q;
   assign auto_idle  = autoidle_q;

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;

   // R8/R9: nothing leaves its default while the reset window is open
   p_hold_defaults_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (status == '0 && enable == '0 && faddr == '0 && ctrl_q == '0));
   // R7: the reserved idle code is never stored
   p_idle_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      idle_q != IDLE_RSVD);
   // R8: a start closes all interrupts at the next edge
   p_srst_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      srst_start |=> (status == '0));
endmodule

// File: tb/test_mmu_fault_regs.sv
`timescale 1ns/100ps
module test_mmu_fault_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [4:0]  fault_evt = '0;
   logic [31:0] fault_va = '0;
   logic        irq, xlat_en, walk_en, emu_tlb_en, auto_idle;
   logic [1:0]  idle_mode;

   int checks = 0;
   int failures = 0;
   int edges = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) edges++;

   mmu_fault_regs i_mmu_fault_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fault_evt(fault_evt),
      .fault_va(fault_va), .irq(irq), .xlat_en(xlat_en), .walk_en(walk_en),
      .emu_tlb_en(emu_tlb_en), .idle_mode(idle_mode), .auto_idle(auto_idle)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.4;
      d = reg_rdata;
   endtask

   task automatic pulse(logic [4:0] e, logic [31:0] va);
      @(negedge clk);
      fault_evt = e; fault_va = va;
      @(negedge clk);
      fault_evt = '0;
   endtask

   function automatic logic [31:0] cfg_word(int idle, bit ai);
      return 32'(idle << 3) | 32'(ai);
   endfunction

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(4 * 100000);
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      logic [4:0]  m_st, m_en;
      logic [31:0] m_fa;
      int e0;
      void'($urandom(32'd4242));
      #5 rst_n = 1'b1;
      @(negedge clk);

      // R1 / R10 reset state
      rd(3'd0, d); chk("R10 revision", d, 32'h11);
      rd(3'd1, d); chk("R1 config", d, 0);
      rd(3'd2, d); chk("R1 reset done", d, 1);
      rd(3'd3, d); chk("R1 status", d, 0);
      rd(3'd4, d); chk("R1 enable", d, 0);
      rd(3'd5, d); chk("R1 control", d, 0);
      rd(3'd6, d); chk("R1 fault addr", d, 0);
      rd(3'd7, d); chk("R1 unused index", d, 0);
      chk("R1 irq", irq, 0);

      // R2 / R5: each source sets its bit; first address is captured
      pulse(5'b00001, 32'hA000_1000);
      rd(3'd3, d); chk("R2 tlb miss bit", d, 32'h01);
      rd(3'd6, d); chk("R5 first capture", d, 32'hA000_1000);
      chk("R4 no irq while disabled", irq, 0);
      for (int k = 1; k < 5; k++) begin
         pulse(5'(1 << k), 32'hB000_0000 + 32'(k));
         rd(3'd3, d); chk("R2 source bit", d[k], 1);
      end
      rd(3'd3, d); chk("R2 all sticky", d, 32'h1F);
      rd(3'd6, d); chk("R5 nothing enabled recaptures", d, 32'hB000_0004);

      // R4: enable selects
      wr(3'd4, 32'h08);
      chk("R4 irq on enabled", irq, 1);
      pulse(5'b00010, 32'hC0DE_0000);
      rd(3'd6, d); chk("R5 held while pending", d, 32'hB000_0004);

      // R3: partial clear, and set wins over clear
      wr(3'd3, 32'h0C);
      rd(3'd3, d); chk("R3 partial clear", d, 32'h13);
      chk("R4 irq drops", irq, 0);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h03; fault_evt = 5'b00001;
      @(negedge clk);
      reg_we = 1'b0; fault_evt = '0;
      rd(3'd3, d); chk("R3 set wins over clear", d, 32'h11);

      // R6 control
      wr(3'd5, 32'hFFFF_FFFF);
      rd(3'd5, d); chk("R6 control readback", d, 32'h0E);
      chk("R6 outputs", {xlat_en, walk_en, emu_tlb_en}, 3'b111);
      wr(3'd5, 32'h04);
      chk("R6 walk needs translation", {xlat_en, walk_en, emu_tlb_en}, 3'b000);

      // R7 config
      wr(3'd1, cfg_word(2, 1'b1));
      rd(3'd1, d); chk("R7 config readback", d, 32'h11);
      chk("R7 outputs", {idle_mode, auto_idle}, 3'b101);
      wr(3'd1, cfg_word(3, 1'b0));
      rd(3'd1, d); chk("R7 reserved idle ignored", d, 32'h10);
      wr(3'd1, cfg_word(1, 1'b0));
      chk("R7 idle none", idle_mode, 2'd1);

      // R8 / R9 soft reset
      wr(3'd5, 32'h0E);
      wr(3'd4, 32'h1F);
      wr(3'd1, 32'h2);
      e0 = edges;
      rd(3'd2, d); chk("R8 done low", d, 0);
      rd(3'd1, d); chk("R8 config during reset", d, 32'h02);
      rd(3'd5, d); chk("R8 control default", d, 0);
      rd(3'd4, d); chk("R8 enable default", d, 0);
      rd(3'd3, d); chk("R8 status default", d, 0);
      chk("R8 irq low", irq, 0);
      pulse(5'b11111, 32'hDEAD_BEEF);
      wr(3'd5, 32'h0E);
      rd(3'd3, d); chk("R9 event ignored", d, 0);
      rd(3'd6, d); chk("R9 address ignored", d, 0);
      rd(3'd5, d); chk("R9 write ignored", d, 0);
      rd(3'd2, d);
      while (d[0] == 1'b0 && edges - e0 < 40) begin
         @(negedge clk);
         rd(3'd2, d);
      end
      chk("R8 done after 16 edges", 32'(edges - e0), 32'd16);
      rd(3'd1, d); chk("R8 trigger cleared", d, 0);

      // Random phase, R2-R5 against a model
      m_st = '0; m_en = '0; m_fa = '0;
      for (int it = 0; it < 400; it++) begin
         logic [4:0]  ev;
         logic [31:0] va, wd;
         int op;
         ev = ($urandom % 3 == 0) ? 5'($urandom) : 5'd0;
         va = $urandom;
         op = $urandom % 4;
         wd = 32'($urandom);
         @(negedge clk);
         fault_evt = ev; fault_va = va;
         if (op == 1) begin reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = wd; end
         if (op == 2) begin reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = wd; end
         @(posedge clk);
         #0.4;
         reg_we = 1'b0; fault_evt = '0;
         if ((|ev) && !(|(m_st & m_en))) m_fa = va;
         if (op == 1) m_st = m_st & ~wd[4:0];
         m_st = m_st | ev;
         if (op == 2) m_en = wd[4:0];
         rd(3'd3, d); chk("R2/R3 random status", d, 32'(m_st));
         rd(3'd6, d); chk("R5 random address", d, m_fa);
         chk("R4 random irq", irq, |(m_st & m_en));
      end

      finish_run();
   end
endmodule